// File: doc/BRIEF.md
# Cascadable Dual Prescaler Timebase

This block is a low-frequency timebase built from two 8-bit up-counters in a single clock domain. The two slow time sources arrive as one-cycle tick enables. A select bit picks which tick advances the low counter. The high counter either follows its own tick, or is chained behind the low counter so that the pair forms one 16-bit count. In the chained mode the high counter advances on the low counter's carry.

Software reaches both counters, a control register and an interrupt register over a small synchronous register bus. Writes land on the rising clock edge, and reads are combinational from the address. A 3-bit interval field picks one bit of the high counter. When an increment drives that bit from 0 to 1, a sticky interrupt flag is set. The flag drives the interrupt request only while its enable bit is set. The control register has no reset, so it keeps its contents through a reset and software configures it after start-up.

Top module: `cascade_prescale_timer`

## Requirements
- R1: While rst_ni is low and after its release, both counters read 0, the flag and enable bits read 0, and irq_o is 0.
- R2: The control register (address 0) is not changed by rst_ni: a value written before a reset reads back unchanged after it.
- R3: The control register holds the source select in bit 0. With bit 0 clear, the low counter (address 1) advances by one on a cycle with tick_a_i high. With bit 0 set, it advances on tick_b_i instead. With no selected tick, the low counter holds its value.
- R4: The control register holds the chaining bit in bit 1. With bit 1 clear, the high counter (address 2) advances by one on each cycle with tick_b_i high, independent of the low counter. Each counter wraps from 8'hFF to 8'h00.
- R5: With bit 1 set, the high counter advances only in a cycle where the low counter steps from 8'hFF to 8'h00, and otherwise holds.
- R6: A bus write to a counter loads the written byte on that edge, even when an increment is due in the same cycle.
- R7: The control register holds the interval field k in bits 4:2. The flag is set when an increment of the high counter makes its bit k change from 0 to 1. Bus writes to the high counter never set the flag.
- R8: Address 3 holds the flag in bit 0. Writing 1 to that bit clears the flag and writing 0 leaves it alone. If a set event and a clear happen in the same cycle, the flag ends set.
- R9: Bit 1 of address 3 is the interrupt enable, written directly. irq_o is high exactly when the flag and the enable are both 1.
- R10: Reads return the control register as {3'b000, k, chain, select} at address 0, the counters at addresses 1 and 2, and {6'b0, enable, flag} at address 3. Control bits 7:5 are ignored on write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (counters, flag, enable) |
| tick_a_i | input | 1 | First slow time source, one-cycle enable |
| tick_b_i | input | 1 | Second slow time source, one-cycle enable |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for reg_addr_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench drives the low counter across 8'hFF while chaining is on and checks for a single high-counter step. A design that derives the carry from the counter value alone would step the high counter on every idle cycle at 8'hFF. It also collides a counter write with a due increment and a flag clear with a same-cycle set event. A wrong priority shows up as a counter that is off by one or as a lost interrupt. A reset is issued between a control write and its read-back, which catches a control register wrongly placed on the reset. Random ticks, selects, taps and writes cover the mode switches and the rule that high-counter writes must not set the flag.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  localparam int unsigned CNT_W  = 8;
  localparam int unsigned TAP_W  = $clog2(CNT_W);
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    ADR_CTRL = 2'd0,
    ADR_LO   = 2'd1,
    ADR_HI   = 2'd2,
    ADR_IRQ  = 2'd3
  } reg_addr_e;

  typedef struct packed {
    logic [TAP_W-1:0] tap;
    logic             chain;
    logic             src_sel;
  } ctrl_t;
endpackage

// File: rtl/cpt_tick_route.sv
module cpt_tick_route (
  input  logic src_sel_i,
  input  logic chain_i,
  input  logic tick_a_i,
  input  logic tick_b_i,
  input  logic lo_carry_i,
  output logic lo_inc_o,
  output logic hi_inc_o
);
  always_comb begin
    lo_inc_o = src_sel_i ? tick_b_i : tick_a_i;
    hi_inc_o = chain_i ? lo_carry_i : tick_b_i;
  end
endmodule

// File: rtl/cpt_counter.sv
module cpt_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o,
  output logic         carry_o
);
  // write beats increment
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (we_i)  q_o <= wdata_i;
    else if (inc_i) q_o <= q_o + 1'b1;
  end

  assign carry_o = inc_i & ~we_i & (&q_o);

  AST_WRITE_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> q_o == $past(wdata_i)); // R6
  AST_INC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inc_i && !we_i |=> q_o == W'($past(q_o) + 1'b1)); // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inc_i && !we_i |=> $stable(q_o)); // R3
endmodule

// File: rtl/cpt_tap_flag.sv
module cpt_tap_flag #(
  parameter int unsigned W     = 8,
  parameter int unsigned TAP_W = $clog2(W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [W-1:0]     q_i,
  input  logic             inc_i,
  input  logic             we_i,
  input  logic [TAP_W-1:0] tap_i,
  input  logic             clr_i,
  output logic             flag_o
);
  logic [W-1:0] q_next;
  logic         set_evt;

  always_comb begin
    q_next  = q_i + 1'b1;
    set_evt = inc_i & ~we_i & ~q_i[tap_i] & q_next[tap_i];
  end

  // set beats clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      flag_o <= 1'b0;
    else if (set_evt) flag_o <= 1'b1;
    else if (clr_i)   flag_o <= 1'b0;
  end

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_evt && clr_i |=> flag_o); // R8
  AST_CLEAR_TAKES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_evt |=> !flag_o); // R8
  AST_NO_SET_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && !clr_i && !flag_o |=> !flag_o); // R7
endmodule

// File: rtl/cascade_prescale_timer.sv
module cascade_prescale_timer
  import cpt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_a_i,
  input  logic              tick_b_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [CNT_W-1:0]  reg_wdata_i,
  output logic [CNT_W-1:0]  reg_rdata_o,
  output logic              irq_o
);
  localparam int unsigned N_CNT   = 2;
  localparam int unsigned CTRL_W  = $bits(ctrl_t);

  ctrl_t            ctrl_q;
  logic             ie_q;
  logic             flag;
  logic [CNT_W-1:0] cnt_q  [N_CNT];
  logic             cnt_we [N_CNT];
  logic             cnt_inc[N_CNT];
  logic             cnt_cy [N_CNT];
  logic             wr_ctrl, wr_irq;

  always_comb begin
    wr_ctrl   = reg_we_i && (reg_addr_i == ADR_CTRL);
    wr_irq    = reg_we_i && (reg_addr_i == ADR_IRQ);
    cnt_we[0] = reg_we_i && (reg_addr_i == ADR_LO);
    cnt_we[1] = reg_we_i && (reg_addr_i == ADR_HI);
  end

  // control register deliberately outside the reset domain
  always_ff @(posedge clk_i) begin
    if (wr_ctrl) ctrl_q <= ctrl_t'(reg_wdata_i[CTRL_W-1:0]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ie_q <= 1'b0;
    else if (wr_irq) ie_q <= reg_wdata_i[1];
  end

  cpt_tick_route i_route (
    .src_sel_i  (ctrl_q.src_sel),
    .chain_i    (ctrl_q.chain),
    .tick_a_i   (tick_a_i),
    .tick_b_i   (tick_b_i),
    .lo_carry_i (cnt_cy[0]),
    .lo_inc_o   (cnt_inc[0]),
    .hi_inc_o   (cnt_inc[1])
  );

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    cpt_counter #(.W(CNT_W)) i_cnt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .inc_i   (cnt_inc[g]),
      .we_i    (cnt_we[g]),
      .wdata_i (reg_wdata_i),
      .q_o     (cnt_q[g]),
      .carry_o (cnt_cy[g])
    );
  end

  cpt_tap_flag #(.W(CNT_W), .TAP_W(TAP_W)) i_flag (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .q_i    (cnt_q[1]),
    .inc_i  (cnt_inc[1]),
    .we_i   (cnt_we[1]),
    .tap_i  (ctrl_q.tap),
    .clr_i  (wr_irq && reg_wdata_i[0]),
    .flag_o (flag)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADR_CTRL: reg_rdata_o = CNT_W'(ctrl_q);
      ADR_LO:   reg_rdata_o = cnt_q[0];
      ADR_HI:   reg_rdata_o = cnt_q[1];
      default:  reg_rdata_o = CNT_W'({ie_q, flag});
    endcase
    irq_o = flag & ie_q;
  end

  AST_CHAIN_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.chain && cnt_inc[0] && !cnt_we[0] && (&cnt_q[0]) && !cnt_we[1]
    |=> cnt_q[1] == CNT_W'($past(cnt_q[1]) + 1'b1)); // R5
  AST_CHAIN_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_q.chain && !(cnt_inc[0] && (&cnt_q[0])) && !cnt_we[1]
    |=> $stable(cnt_q[1])); // R5
  AST_IRQ_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_irq && !reg_wdata_i[1] |=> !irq_o); // R9
endmodule

// File: tb/test_cascade_prescale_timer.sv
`timescale 1ns/1ps
module test_cascade_prescale_timer;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_a_i = 1'b0, tick_b_i = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [1:0] reg_addr_i = 2'd0;
  logic [7:0] reg_wdata_i = 8'd0;
  logic [7:0] reg_rdata_o;
  logic       irq_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model
  logic [4:0] m_ctrl;
  logic [7:0] m_lo, m_hi;
  logic       m_flag, m_ie;

  always #5 clk_i = ~clk_i;

  cascade_prescale_timer i_cascade_prescale_timer (
    .clk_i, .rst_ni, .tick_a_i, .tick_b_i, .reg_we_i,
    .reg_addr_i, .reg_wdata_i, .reg_rdata_o, .irq_o
  );

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return {3'b000, m_ctrl};
      2'd1: return m_lo;
      2'd2: return m_hi;
      default: return {6'b0, m_ie, m_flag};
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic m_update(input logic we, input logic [1:0] a, input logic [7:0] wd,
                          input logic ta, input logic tb);
    logic inc0, inc1, wr0, wr1, carry, setev;
    logic [7:0] h1;
    inc0  = m_ctrl[0] ? tb : ta;
    wr0   = we && a == 2'd1;
    wr1   = we && a == 2'd2;
    carry = inc0 && !wr0 && m_lo == 8'hFF;
    inc1  = m_ctrl[1] ? carry : tb;
    h1    = m_hi + 8'd1;
    setev = inc1 && !wr1 && !m_hi[m_ctrl[4:2]] && h1[m_ctrl[4:2]];
    if (setev) m_flag = 1'b1;
    else if (we && a == 2'd3 && wd[0]) m_flag = 1'b0;
    if (we && a == 2'd3) m_ie = wd[1];
    if (wr0) m_lo = wd; else if (inc0) m_lo = m_lo + 8'd1;
    if (wr1) m_hi = wd; else if (inc1) m_hi = h1;
    if (we && a == 2'd0) m_ctrl = wd[4:0];
  endtask

  // drive at negedge, check pre-edge state, then model the edge
  task automatic step(input string tag, input logic we, input logic [1:0] a,
                      input logic [7:0] wd, input logic ta, input logic tb);
    @(negedge clk_i);
    reg_we_i = we; reg_addr_i = a; reg_wdata_i = wd; tick_a_i = ta; tick_b_i = tb;
    #1;
    chk(tag, "rdata", reg_rdata_o, m_read(a));
    chk(tag, "irq", {7'b0, irq_o}, {7'b0, m_flag & m_ie});
    @(posedge clk_i);
    m_update(we, a, wd, ta, tb);
  endtask

  task automatic idle_read(input string tag, input logic [1:0] a);
    step(tag, 1'b0, a, 8'h00, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    reg_we_i = 1'b0; tick_a_i = 1'b0; tick_b_i = 1'b0;
    rst_ni = 1'b0;
    m_lo = 8'h00; m_hi = 8'h00; m_flag = 1'b0; m_ie = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    m_ctrl = 5'd0;
    m_lo = 8'h00; m_hi = 8'h00; m_flag = 1'b0; m_ie = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    // configure control before any tick
    step("R10", 1'b1, 2'd0, 8'h00, 1'b0, 1'b0);

    // R1 reset state
    for (int a = 1; a < 4; a++) idle_read("R1", 2'(a));

    // R2 control survives reset
    step("R2", 1'b1, 2'd0, 8'hF6, 1'b0, 1'b0);
    do_reset();
    idle_read("R2", 2'd0);
    idle_read("R1", 2'd1);

    // R3 select tick_a vs tick_b for low counter
    step("R3", 1'b1, 2'd0, 8'h00, 1'b0, 1'b0);
    step("R3", 1'b0, 2'd1, 8'h00, 1'b1, 1'b0);
    step("R3", 1'b0, 2'd1, 8'h00, 1'b0, 1'b1);
    step("R3", 1'b1, 2'd0, 8'h01, 1'b0, 1'b0);
    step("R3", 1'b0, 2'd1, 8'h00, 1'b1, 1'b0);
    step("R3", 1'b0, 2'd1, 8'h00, 1'b0, 1'b1);
    idle_read("R3", 2'd1);

    // R4 independent high counter wraps
    step("R4", 1'b1, 2'd0, 8'h00, 1'b0, 1'b0);
    step("R4", 1'b1, 2'd2, 8'hFE, 1'b0, 1'b0);
    step("R4", 1'b0, 2'd2, 8'h00, 1'b0, 1'b1);
    step("R4", 1'b0, 2'd2, 8'h00, 1'b0, 1'b1);
    idle_read("R4", 2'd2);

    // R5 chained carry, one step per wrap only
    step("R5", 1'b1, 2'd0, 8'h02, 1'b0, 1'b0);
    step("R5", 1'b1, 2'd1, 8'hFE, 1'b0, 1'b0);
    step("R5", 1'b1, 2'd2, 8'h10, 1'b0, 1'b0);
    step("R5", 1'b0, 2'd2, 8'h00, 1'b1, 1'b1);
    step("R5", 1'b0, 2'd2, 8'h00, 1'b0, 1'b1);
    step("R5", 1'b0, 2'd2, 8'h00, 1'b1, 1'b1);
    step("R5", 1'b0, 2'd2, 8'h00, 1'b1, 1'b0);
    idle_read("R5", 2'd1);

    // R6 write beats increment
    step("R6", 1'b1, 2'd1, 8'h5A, 1'b1, 1'b0);
    idle_read("R6", 2'd1);
    step("R6", 1'b1, 2'd0, 8'h00, 1'b0, 1'b0);
    step("R6", 1'b1, 2'd2, 8'hA5, 1'b0, 1'b1);
    idle_read("R6", 2'd2);

    // R7 tap k=2: rise of bit 2 from 8'h03 -> 8'h04; write does not set
    step("R7", 1'b1, 2'd3, 8'h01, 1'b0, 1'b0);
    step("R7", 1'b1, 2'd0, 8'h08, 1'b0, 1'b0);
    step("R7", 1'b1, 2'd2, 8'h04, 1'b0, 1'b0);
    idle_read("R7", 2'd3);
    step("R7", 1'b1, 2'd2, 8'h03, 1'b0, 1'b0);
    step("R7", 1'b0, 2'd3, 8'h00, 1'b0, 1'b1);
    idle_read("R7", 2'd3);

    // R9 enable gates irq
    step("R9", 1'b1, 2'd3, 8'h02, 1'b0, 1'b0);
    idle_read("R9", 2'd3);
    step("R9", 1'b1, 2'd3, 8'h00, 1'b0, 1'b0);
    idle_read("R9", 2'd3);

    // R8 clear alone, then clear colliding with set
    step("R8", 1'b1, 2'd3, 8'h03, 1'b0, 1'b0);
    idle_read("R8", 2'd3);
    step("R8", 1'b1, 2'd2, 8'h03, 1'b0, 1'b0);
    step("R8", 1'b1, 2'd3, 8'h03, 1'b0, 1'b1);
    idle_read("R8", 2'd3);

    // R10 ignored upper control bits
    step("R10", 1'b1, 2'd0, 8'hE3, 1'b0, 1'b0);
    idle_read("R10", 2'd0);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic we;
      logic [1:0] a;
      logic [7:0] wd;
      we = ($urandom_range(0, 3) == 0);
      a  = 2'($urandom_range(0, 3));
      wd = 8'($urandom);
      if (we && a == 2'd1 && $urandom_range(0, 1) == 1) wd = 8'hFD;
      step("R10", we, a, wd, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule